// File: doc/BRIEF.md
# Four-Lane Sample Interleaver with Ramp Test Source

This block sits between a wide, slow parallel data capture and a converter core that consumes one 12-bit sample per fast clock. Four 12-bit lanes arrive together. A group strobe, given once per slow input period, loads them into a holding register. The block then emits the held lanes one after another on the fast clock. It can emit a single lane every cycle, two lanes alternately, or all four lanes in turn.

A self-test selection replaces the lane data with an internal 12-bit ramp. The ramp starts at zero and climbs by one code on each fast clock, so the converter can be driven across its whole code range with no external pattern source. The ratio and self-test settings come from static control inputs. They are only taken in on a group strobe, so a group never changes shape part way through. A valid flag marks the output untrustworthy for the first group after reset and for the first group after any change of setting.

Top module: `lane_interleaver`

## Requirements
- R1: While reset is held and after its release until the first group strobe, `sample_o` is 0 and `valid_o` is 0.
- R2: On a clock edge where `grp_strobe_i` is high, all four lanes are loaded together. Lane k occupies bits [12k+11:12k] of `lanes_i`. Lane values applied on edges without the strobe are never emitted.
- R3: With ratio code 1 (two-lane), the output alternates lane 0, lane 1, starting with lane 0 in the cycle after the strobe edge.
- R4: With ratio code 2 (four-lane), the output runs lane 0, 1, 2, 3 in consecutive cycles, starting in the cycle after the strobe edge.
- R5: With ratio code 0 (single lane), every output cycle carries lane 0 of the most recent load.
- R6: A strobe that arrives before a group is complete restarts the sequence at lane 0 in the next cycle.
- R7: `ratio_i` and `bist_i` are sampled only on strobe edges. Changes between strobes have no effect on the output or on `valid_o`.
- R8: With self-test selected, `sample_o` shows the ramp and ignores the lanes. The ramp reads 0 in the cycle after the strobe that enters self-test and rises by one each cycle after that, including across later strobes while self-test stays selected.
- R9: The ramp passes through all 4096 codes and wraps from 4095 to 0.
- R10: `valid_o` changes only after strobe edges. It is 0 for the group after the first strobe following reset, and for any group whose strobe changes the ratio code or the self-test selection. Otherwise it is 1.
- R11: Ratio code 3 emits lane 0 every cycle, as code 0 does, but it counts as a distinct setting for R10.
- R12: If a group runs longer than its ratio without a new strobe, the sequence wraps to lane 0 and replays the held lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_strobe_i | input | 1 | Marks the first cycle of a group; loads lanes and settings |
| lanes_i | input | 48 | Four 12-bit lanes, lane k at bits [12k+11:12k] |
| ratio_i | input | 2 | Interleave ratio: 0 one lane, 1 two lanes, 2 four lanes, 3 one lane |
| bist_i | input | 1 | Selects the internal ramp as the sample source |
| sample_o | output | 12 | Serialized output sample |
| valid_o | output | 1 | High once the current group follows a group of the same settings |

## Verification
Every output is due in the cycle right after the rising edge that registers its cause. A strobe edge loads the lanes and settings, and the first lane, the first ramp code and the new valid value appear one register later. Each later edge moves the phase or the ramp on by one. The driver changes inputs on falling edges and queues exactly one expected sample and valid value per edge it drives. The monitor removes one entry 5 ns after each following rising edge, so each expectation is compared against the cycle it describes. Between strobes the driver changes the lanes, the ratio and the self-test input, which shows that none of them reaches the output early.

// File: rtl/lane_mux_pkg.sv
package lane_mux_pkg;

    localparam int unsigned LANE_CNT = 4;
    localparam int unsigned PHASE_W  = $clog2(LANE_CNT);

    typedef enum logic [1:0] {
        RATIO_ONE  = 2'b00,
        RATIO_TWO  = 2'b01,
        RATIO_FOUR = 2'b10,
        RATIO_ALT  = 2'b11
    } ratio_e;

    typedef logic [PHASE_W-1:0] phase_t;

    // Highest phase index reached in one group for a given ratio.
    function automatic phase_t last_phase(ratio_e r);
        case (r)
            RATIO_TWO:  return phase_t'(1);
            RATIO_FOUR: return phase_t'(LANE_CNT - 1);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/lane_hold.sv
module lane_hold
    import lane_mux_pkg::*;
#(
    parameter int unsigned W = 12,
    parameter int unsigned N = LANE_CNT
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  logic [N*W-1:0] lanes_i,
    input  phase_t         sel_i,
    output logic [W-1:0]   sample_o
);

    typedef struct packed {
        logic [N*W-1:0] lanes;
    } hold_s;

    hold_s hold_d, hold_q;
    logic [W-1:0] lane_w [N];

    always_comb begin
        hold_d = hold_q;
        if (load_i) begin
            hold_d.lanes = lanes_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_lane
        assign lane_w[k] = hold_q.lanes[k*W +: W];
    end

    assign sample_o = lane_w[sel_i];

endmodule

// File: rtl/phase_seq.sv
module phase_seq
    import lane_mux_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   restart_i,
    input  phase_t last_i,
    output phase_t phase_o
);

    typedef struct packed {
        phase_t phase;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (restart_i || (seq_q.phase == last_i)) begin
            seq_d.phase = '0;
        end else begin
            seq_d.phase = seq_q.phase + phase_t'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;

endmodule

// File: rtl/bist_ramp.sv
module bist_ramp #(
    parameter int unsigned W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    output logic [W-1:0] code_o
);

    typedef struct packed {
        logic [W-1:0] code;
    } ramp_s;

    ramp_s ramp_d, ramp_q;

    // Held at zero while idle, so the first code after entry is always 0.
    always_comb begin
        ramp_d = ramp_q;
        if (run_i) begin
            ramp_d.code = ramp_q.code + W'(1);
        end else begin
            ramp_d.code = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ramp_q <= '0;
        end else begin
            ramp_q <= ramp_d;
        end
    end

    assign code_o = ramp_q.code;

endmodule

// File: rtl/lane_interleaver.sv
module lane_interleaver
    import lane_mux_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         grp_strobe_i,
    input  logic [LANE_CNT*SAMPLE_W-1:0] lanes_i,
    input  logic [1:0]                   ratio_i,
    input  logic                         bist_i,
    output logic [SAMPLE_W-1:0]          sample_o,
    output logic                         valid_o
);

    typedef struct packed {
        ratio_e ratio;
        logic   bist;
        logic   started;
        logic   valid;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    phase_t              phase_w;
    logic [SAMPLE_W-1:0] lane_sample_w;
    logic [SAMPLE_W-1:0] ramp_code_w;
    logic [1:0]          mode_ratio_w;
    logic                mode_bist_w;

    // Settings are taken only at a group boundary.
    always_comb begin
        ctrl_d = ctrl_q;
        if (grp_strobe_i) begin
            ctrl_d.ratio   = ratio_e'(ratio_i);
            ctrl_d.bist    = bist_i;
            ctrl_d.started = 1'b1;
            ctrl_d.valid   = ctrl_q.started
                           && (ratio_i == ctrl_q.ratio)
                           && (bist_i == ctrl_q.bist);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{ratio: RATIO_ONE, bist: 1'b0, started: 1'b0, valid: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    lane_hold #(
        .W (SAMPLE_W),
        .N (LANE_CNT)
    ) u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (grp_strobe_i),
        .lanes_i  (lanes_i),
        .sel_i    (phase_w),
        .sample_o (lane_sample_w)
    );

    phase_seq u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (grp_strobe_i),
        .last_i    (last_phase(ctrl_q.ratio)),
        .phase_o   (phase_w)
    );

    bist_ramp #(
        .W (SAMPLE_W)
    ) u_ramp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (ctrl_q.bist),
        .code_o (ramp_code_w)
    );

    assign mode_ratio_w = ctrl_q.ratio;
    assign mode_bist_w  = ctrl_q.bist;
    assign sample_o     = ctrl_q.bist ? ramp_code_w : lane_sample_w;
    assign valid_o      = ctrl_q.valid;

endmodule

// File: rtl/lane_interleaver_checks.sv
module lane_interleaver_checks
    import lane_mux_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         strobe_i,
    input logic [1:0]   ratio_i,
    input logic         bist_i,
    input logic [W-1:0] sample_o,
    input logic         valid_o,
    input phase_t       phase,
    input logic [1:0]   ratio_q,
    input logic         bist_q
);

    assert_phase_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i |=> (phase == '0));

    assert_settings_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> ($stable(ratio_q) && $stable(bist_q)));

    assert_single_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ratio_q == RATIO_ONE) || (ratio_q == RATIO_ALT)) |-> (phase == '0));

    assert_ramp_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && bist_i && !bist_q) |=> (sample_o == '0));

    assert_ramp_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bist_q && !strobe_i) |=> ((sample_o - $past(sample_o)) == W'(1)));

    assert_valid_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && ((ratio_i != ratio_q) || (bist_i != bist_q))) |=> !valid_o);

    assert_valid_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(valid_o));

endmodule

bind lane_interleaver lane_interleaver_checks #(.W(SAMPLE_W)) u_checks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (grp_strobe_i),
    .ratio_i  (ratio_i),
    .bist_i   (bist_i),
    .sample_o (sample_o),
    .valid_o  (valid_o),
    .phase    (phase_w),
    .ratio_q  (mode_ratio_w),
    .bist_q   (mode_bist_w)
);

// File: tb/lane_interleaver_test.sv
module lane_interleaver_test;

    localparam int W = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic           strobe;
    logic [4*W-1:0] lanes;
    logic [1:0]     ratio;
    logic           bist;
    logic [W-1:0]   sample;
    logic           valid;

    lane_interleaver #(.SAMPLE_W(W)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .grp_strobe_i (strobe),
        .lanes_i      (lanes),
        .ratio_i      (ratio),
        .bist_i       (bist),
        .sample_o     (sample),
        .valid_o      (valid)
    );

    typedef struct {
        logic [W-1:0] data;
        logic         valid;
        string        req;
    } exp_t;

    exp_t           sb[$];
    exp_t           got;
    int             checks = 0;
    int             errors = 0;
    logic [W-1:0]   ramp_m = '0;
    logic           bist_m = 1'b0;
    logic [4*W-1:0] held   = '0;

    function automatic logic [4*W-1:0] mk(input logic [W-1:0] base);
        return {base + W'(3), base + W'(2), base + W'(1), base};
    endfunction

    task automatic check_now(input logic [W-1:0] exp_d, input logic exp_v, input string req);
        checks++;
        if (sample !== exp_d || valid !== exp_v) begin
            errors++;
            $display("FAIL %s: sample=%h valid=%b expected sample=%h valid=%b",
                     req, sample, valid, exp_d, exp_v);
        end
    endtask

    // Driver: one group, strobe on its first cycle, one expectation per cycle.
    task automatic run_group(input logic [4*W-1:0] lv, input logic [1:0] r, input logic b,
                             input int len, input logic exp_v, input logic noise,
                             input string req);
        int   n = (r == 2'd1) ? 2 : (r == 2'd2) ? 4 : 1;
        exp_t e;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (c == 0) begin
                strobe = 1'b1;
                lanes  = lv;
                ratio  = r;
                bist   = b;
                held   = lv;
                if (b && !bist_m) ramp_m = '0;
                else if (b)       ramp_m = ramp_m + W'(1);
                bist_m = b;
            end else begin
                strobe = 1'b0;
                if (noise) begin
                    lanes = ~lv;
                    ratio = r ^ 2'b11;
                    bist  = ~b;
                end
                if (bist_m) ramp_m = ramp_m + W'(1);
            end
            e.data  = bist_m ? ramp_m : held[(c % n)*W +: W];
            e.valid = exp_v;
            e.req   = req;
            sb.push_back(e);
        end
    endtask

    // Monitor: compares one expectation 5 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                got = sb.pop_front();
                check_now(got.data, got.valid, got.req);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): cycles=200000 expected completion earlier");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        strobe = 1'b0;
        lanes  = mk(12'h5A0);
        ratio  = 2'd0;
        bist   = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check_now('0, 1'b0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) begin
            @(posedge clk);
            #5;
            check_now('0, 1'b0, "R1 after release");
        end

        // Single lane (R5), first group after reset invalid (R10)
        run_group(mk(12'h100), 2'd0, 1'b0, 1, 1'b0, 1'b1, "R5 R10");
        run_group(mk(12'h110), 2'd0, 1'b0, 1, 1'b1, 1'b1, "R5 R2");
        run_group(mk(12'h120), 2'd0, 1'b0, 1, 1'b1, 1'b1, "R5");
        run_group(mk(12'h130), 2'd0, 1'b0, 1, 1'b1, 1'b1, "R5 R2");

        // Two-lane (R3) with noise between strobes (R7)
        run_group(mk(12'h200), 2'd1, 1'b0, 2, 1'b0, 1'b1, "R3 R10");
        run_group(mk(12'h210), 2'd1, 1'b0, 2, 1'b1, 1'b1, "R3 R7");
        run_group(mk(12'h220), 2'd1, 1'b0, 2, 1'b1, 1'b1, "R3 R2");

        // Four-lane (R4), early strobe (R6), overlong group (R12)
        run_group(mk(12'h300), 2'd2, 1'b0, 4, 1'b0, 1'b1, "R4 R10");
        run_group(mk(12'h310), 2'd2, 1'b0, 4, 1'b1, 1'b1, "R4 R7");
        run_group(mk(12'h320), 2'd2, 1'b0, 2, 1'b1, 1'b1, "R6");
        run_group(mk(12'h330), 2'd2, 1'b0, 4, 1'b1, 1'b1, "R6 R4");
        run_group(mk(12'h340), 2'd2, 1'b0, 6, 1'b1, 1'b0, "R12");

        // Ratio code 3 (R11)
        run_group(mk(12'h400), 2'd3, 1'b0, 3, 1'b0, 1'b1, "R11 R10");
        run_group(mk(12'h410), 2'd3, 1'b0, 1, 1'b1, 1'b1, "R11");

        // Ramp source: entry, full wrap, continuity across strobes (R8, R9)
        run_group(mk(12'h500), 2'd2, 1'b1, 4100, 1'b0, 1'b1, "R8 R9");
        run_group(mk(12'h510), 2'd2, 1'b1, 4, 1'b1, 1'b1, "R8 R10");
        run_group(mk(12'h520), 2'd2, 1'b0, 4, 1'b0, 1'b1, "R10 R8 exit");
        run_group(mk(12'h530), 2'd1, 1'b1, 3, 1'b0, 1'b1, "R8 reentry");
        run_group(mk(12'h540), 2'd1, 1'b1, 2, 1'b1, 1'b1, "R8");

        @(negedge clk);
        strobe = 1'b0;
        repeat (3) @(posedge clk);
        #6;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule